// File: doc/BRIEF.md
# Host Memory Access Port

This block is a slave port through which an external host reads and writes the chip's internal program and data memories over one 16-bit multiplexed address/data bus. The host uses four strobes: select, address latch, read and write. Each strobe passes through a two-flop synchroniser into the core clock, and the block acts on the edges it detects there. A latch phase loads either a starting address with a memory-space bit or an overlay number. After that, read and write phases move one bus word each. The address steps forward by itself, so a block of consecutive words needs only one latch phase.

Data memory words are 16 bits wide and take one bus transfer each. Program memory words are 24 bits wide and take two transfers: first the upper 16 bits, then the low byte. The acknowledge line is low while a phase is in progress. A memory access waits for a grant from the core before it completes. Host writes cannot reach the block of data-memory control registers at the top of the array, and no path returns the latched address to the host.

Top module: `host_mem_port`

## Requirements
- R1: The block acts on a strobe change only after synchronisation. The acknowledge output falls at the third rising clock edge after the strobe changes.
- R2: When latch word bit 15 is 0, bits 13:0 become the access address. Bit 14 selects the memory: 1 means program memory, 0 means data memory. The program-word half pointer returns to the upper half.
- R3: When latch word bit 15 is 1 and bits 14:8 are all zero, bits 7:0 appear on `ovl_o` and the access address does not change. If any of bits 14:8 is set, the whole latch word is ignored.
- R4: The block captures the latch word on the falling edge of the latch strobe. Latch, read and write strobes have no effect while select is low.
- R5: The access address increases by one after each completed data-memory access and after the second half of each program-memory word. The address wraps at 14 bits.
- R6: A program word moves as two transfers. The first carries bits 23:8. The second carries bits 7:0 in bus bits 7:0. On reads, bus bits 15:8 are zero on the second transfer; on writes, they are ignored.
- R7: The acknowledge output is low from the detected strobe edge until the phase completes. A read or write phase completes on the first clock edge at which `grant_i` is high. A latch phase completes one cycle after detection.
- R8: Data-memory writes to addresses at or above DM_DEPTH-CTRL_REGS (224 by default) leave memory unchanged. The handshake still completes and the address still increments.
- R9: Writes to an address beyond the array size leave memory unchanged. Reads from such an address return zero.
- R10: After reset, the acknowledge output is high, `ovl_o` is 0, the output enable is low, and the access address is data-memory word 0 with the half pointer on the upper half.
- R11: A write phase starts on the falling edge of the write strobe. A read phase starts on the rising edge of the read strobe. The bus output enable is high while both select and read are high after synchronisation. Read data stays on `host_ad_o` until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host select, active high |
| host_latch_i | input | 1 | Address latch strobe; captured on its falling edge |
| host_rd_i | input | 1 | Read strobe, active high |
| host_wr_i | input | 1 | Write strobe, active high; acted on at its falling edge |
| host_ad_i | input | 16 | Address/data bus from the host |
| host_ad_o | output | 16 | Read data to the host |
| host_ad_oe_o | output | 1 | Enable for driving the bus |
| host_ack_o | output | 1 | High when idle, low while a phase is in progress |
| grant_i | input | 1 | Core grants a memory access |
| ovl_o | output | 8 | Currently selected overlay |

## Verification
The assertions check on every cycle the following properties:
- A latched address only moves by exactly one, and only after a data word or the second program half.
- The first program half leaves the address in place.
- A pending access stays busy while the grant is low.
- The overlay only changes at the end of a phase.
- No data-memory write ever targets the control-register block.

Only the bench scenarios can show:
- Data round-trips through both memories, including the split of program words and the ignored upper byte.
- The exact acknowledge timing after a strobe.
- That strobes without select, and malformed overlay words, leave no trace.
- That reads outside the array return zero, with the address wrapping to word 0.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  localparam int ADDR_W = 14;
  localparam int BUS_W  = 16;
  localparam int PM_W   = 24;
  localparam int OVL_W  = 8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LATCH = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } hmp_op_e;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/hmp_mem.sv
module hmp_mem
  import hmp_pkg::*;
#(
  parameter int PM_DEPTH = 256,
  parameter int DM_DEPTH = 256,
  parameter int CTRL_REGS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pm_we_i,
  input  logic              dm_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PM_W-1:0]   pm_wdata_i,
  input  logic [BUS_W-1:0]  dm_wdata_i,
  output logic [PM_W-1:0]   pm_rdata_o,
  output logic [BUS_W-1:0]  dm_rdata_o
);
  localparam int PM_IW = (PM_DEPTH > 1) ? $clog2(PM_DEPTH) : 1;
  localparam int DM_IW = (DM_DEPTH > 1) ? $clog2(DM_DEPTH) : 1;
  localparam int CTRL_BASE = DM_DEPTH - CTRL_REGS;

  logic [PM_W-1:0]  pm_mem [PM_DEPTH];
  logic [BUS_W-1:0] dm_mem [DM_DEPTH];

  logic pm_in, dm_in;
  logic [PM_IW-1:0] pm_idx;
  logic [DM_IW-1:0] dm_idx;

  assign pm_in  = int'(addr_i) < PM_DEPTH;
  assign dm_in  = int'(addr_i) < DM_DEPTH;
  assign pm_idx = addr_i[PM_IW-1:0];
  assign dm_idx = addr_i[DM_IW-1:0];

  always_ff @(posedge clk_i) begin
    if (pm_we_i && pm_in) pm_mem[pm_idx] <= pm_wdata_i;
    if (dm_we_i && dm_in) dm_mem[dm_idx] <= dm_wdata_i;
  end

  assign pm_rdata_o = pm_in ? pm_mem[pm_idx] : '0;
  assign dm_rdata_o = dm_in ? dm_mem[dm_idx] : '0;

  // R8: control-register block never written from the host side
  p_ctrl_guard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we_i |-> (int'(addr_i) < CTRL_BASE));
  p_single_we_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pm_we_i && dm_we_i));
endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
  import hmp_pkg::*;
#(
  parameter int DM_DEPTH = 256,
  parameter int CTRL_REGS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_s_i,
  input  logic              latch_s_i,
  input  logic              rd_s_i,
  input  logic              wr_s_i,
  input  logic [BUS_W-1:0]  ad_i,
  input  logic              grant_i,
  input  logic [PM_W-1:0]   pm_rdata_i,
  input  logic [BUS_W-1:0]  dm_rdata_i,
  output logic              pm_we_o,
  output logic              dm_we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PM_W-1:0]   pm_wdata_o,
  output logic [BUS_W-1:0]  dm_wdata_o,
  output logic              ack_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [OVL_W-1:0]  ovl_o
);
  localparam int CTRL_BASE = DM_DEPTH - CTRL_REGS;

  logic latch_q, rd_q, wr_q;
  logic ev_latch, ev_rd, ev_wr, ev_any;
  logic busy_q;
  hmp_op_e op_q, op_d;
  logic [BUS_W-1:0]  ad_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pm_sp_q;
  logic              half_q;
  logic [BUS_W-1:0]  stage_q;
  logic [BUS_W-1:0]  rdata_q;
  logic [OVL_W-1:0]  ovl_q;
  logic do_acc, do_latch, step_addr;

  assign ev_latch = sel_s_i & latch_q & ~latch_s_i;
  assign ev_wr    = sel_s_i & wr_q & ~wr_s_i;
  assign ev_rd    = sel_s_i & rd_s_i & ~rd_q;
  assign ev_any   = ev_latch | ev_wr | ev_rd;

  always_comb begin
    if (ev_latch)   op_d = OP_LATCH;
    else if (ev_wr) op_d = OP_WRITE;
    else if (ev_rd) op_d = OP_READ;
    else            op_d = OP_NONE;
  end

  assign do_latch  = busy_q && (op_q == OP_LATCH);
  assign do_acc    = busy_q && grant_i && (op_q == OP_WRITE || op_q == OP_READ);
  assign step_addr = do_acc && (!pm_sp_q || half_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      latch_q <= latch_s_i;
      rd_q    <= rd_s_i;
      wr_q    <= wr_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      ad_q   <= '0;
    end else if (!busy_q) begin
      if (ev_any) begin
        busy_q <= 1'b1;
        op_q   <= op_d;
        ad_q   <= ad_i;
      end
    end else if (do_latch || do_acc) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      pm_sp_q <= 1'b0;
      half_q  <= 1'b0;
      ovl_q   <= '0;
    end else if (do_latch) begin
      if (!ad_q[15]) begin
        addr_q  <= ad_q[ADDR_W-1:0];
        pm_sp_q <= ad_q[14];
        half_q  <= 1'b0;
      end else if (ad_q[14:8] == 7'd0) begin
        ovl_q <= ad_q[OVL_W-1:0];
      end
    end else if (do_acc) begin
      if (pm_sp_q) half_q <= ~half_q;
      if (step_addr) addr_q <= addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      rdata_q <= '0;
    end else if (do_acc) begin
      if (op_q == OP_WRITE && pm_sp_q && !half_q) stage_q <= ad_q;
      if (op_q == OP_READ) begin
        if (!pm_sp_q)    rdata_q <= dm_rdata_i;
        else if (half_q) rdata_q <= {8'h00, pm_rdata_i[7:0]};
        else             rdata_q <= pm_rdata_i[PM_W-1:8];
      end
    end
  end

  assign pm_we_o    = do_acc && (op_q == OP_WRITE) && pm_sp_q && half_q;
  assign dm_we_o    = do_acc && (op_q == OP_WRITE) && !pm_sp_q
                      && (int'(addr_q) < CTRL_BASE);
  assign addr_o     = addr_q;
  assign pm_wdata_o = {stage_q, ad_q[7:0]};
  assign dm_wdata_o = ad_q;
  assign ack_o      = ~busy_q;
  assign rdata_o    = rdata_q;
  assign ovl_o      = ovl_q;

  p_busy_on_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && ev_any) |=> !ack_o);
  p_hold_no_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !grant_i && op_q != OP_LATCH) |=> (busy_q && $stable(addr_q)));
  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_addr |=> (addr_q == $past(addr_q) + 1'b1));
  p_pm_first_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_acc && pm_sp_q && !half_q) |=> ($stable(addr_q) && half_q));
  p_ovl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(ovl_q));
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmp_pkg::*;
#(
  parameter int PM_DEPTH  = 256,
  parameter int DM_DEPTH  = 256,
  parameter int CTRL_REGS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              host_latch_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [BUS_W-1:0]  host_ad_i,
  output logic [BUS_W-1:0]  host_ad_o,
  output logic              host_ad_oe_o,
  output logic              host_ack_o,
  input  logic              grant_i,
  output logic [OVL_W-1:0]  ovl_o
);
  localparam int NSTB = 4;

  logic [NSTB-1:0]   stb_s;
  logic              pm_we, dm_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [PM_W-1:0]   pm_wdata, pm_rdata;
  logic [BUS_W-1:0]  dm_wdata, dm_rdata;

  hmp_sync #(.N(NSTB)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({host_sel_i, host_latch_i, host_rd_i, host_wr_i}),
    .sync_o  (stb_s)
  );

  hmp_ctrl #(.DM_DEPTH(DM_DEPTH), .CTRL_REGS(CTRL_REGS)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_s_i    (stb_s[3]),
    .latch_s_i  (stb_s[2]),
    .rd_s_i     (stb_s[1]),
    .wr_s_i     (stb_s[0]),
    .ad_i       (host_ad_i),
    .grant_i    (grant_i),
    .pm_rdata_i (pm_rdata),
    .dm_rdata_i (dm_rdata),
    .pm_we_o    (pm_we),
    .dm_we_o    (dm_we),
    .addr_o     (mem_addr),
    .pm_wdata_o (pm_wdata),
    .dm_wdata_o (dm_wdata),
    .ack_o      (host_ack_o),
    .rdata_o    (host_ad_o),
    .ovl_o      (ovl_o)
  );

  hmp_mem #(.PM_DEPTH(PM_DEPTH), .DM_DEPTH(DM_DEPTH), .CTRL_REGS(CTRL_REGS)) i_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pm_we_i    (pm_we),
    .dm_we_i    (dm_we),
    .addr_i     (mem_addr),
    .pm_wdata_i (pm_wdata),
    .dm_wdata_i (dm_wdata),
    .pm_rdata_o (pm_rdata),
    .dm_rdata_o (dm_rdata)
  );

  assign host_ad_oe_o = stb_s[3] & stb_s[1];

  p_oe_needs_sel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ad_oe_o |-> $past(host_sel_i, 2));
endmodule

// File: tb/test_host_mem_port.sv
module test_host_mem_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, latch = 1'b0, rd = 1'b0, wr = 1'b0, grant = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic oe, ack;
  logic [7:0] ovl;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  host_mem_port i_host_mem_port (
    .clk_i(clk), .rst_ni(rst_n), .host_sel_i(sel), .host_latch_i(latch),
    .host_rd_i(rd), .host_wr_i(wr), .host_ad_i(ad_in), .host_ad_o(ad_out),
    .host_ad_oe_o(oe), .host_ack_o(ack), .grant_i(grant), .ovl_o(ovl)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // R7: ack low on third edge, then wait for completion
  task automatic wait_done();
    repeat (3) @(negedge clk);
    check(ack == 1'b0, "R7 busy after strobe", 32'(ack), 0);
    for (int i = 0; i < 60 && !ack; i++) @(negedge clk);
    check(ack == 1'b1, "R7 phase completes", 32'(ack), 1);
  endtask

  task automatic do_latch(input logic [15:0] w);
    @(negedge clk);
    ad_in = w; latch = 1'b1;
    repeat (4) @(negedge clk);
    latch = 1'b0;
    wait_done();
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk);
    ad_in = d; wr = 1'b1;
    repeat (4) @(negedge clk);
    wr = 1'b0;
    wait_done();
  endtask

  task automatic do_read(output logic [15:0] d);
    @(negedge clk);
    rd = 1'b1;
    wait_done();
    d = ad_out;
    check(oe == 1'b1, "R11 output enable during read", 32'(oe), 1);
    rd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [15:0] r, v;
    logic [23:0] pw [6];
    logic [15:0] dw [6];
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(ack == 1'b1, "R10 ack idle", 32'(ack), 1);
    check(oe == 1'b0, "R10 oe low", 32'(oe), 0);
    check(ovl == 8'h00, "R10 overlay zero", 32'(ovl), 0);
    rst_n = 1'b1;
    sel = 1'b1;
    repeat (4) @(negedge clk);

    // R10: default address is DM word 0
    do_write(16'hBEEF);
    do_latch(16'h0000);
    do_read(r);
    check(r == 16'hBEEF, "R10 default DM address 0", 32'(r), 32'hBEEF);

    // R1: exact ack timing after a write strobe falls
    @(negedge clk); ad_in = 16'h0011; wr = 1'b1;
    repeat (4) @(negedge clk);
    wr = 1'b0;
    repeat (2) @(negedge clk);
    check(ack == 1'b1, "R1 no action before third edge", 32'(ack), 1);
    @(negedge clk);
    check(ack == 1'b0, "R1 ack falls at third edge", 32'(ack), 0);
    @(negedge clk);
    check(ack == 1'b1, "R7 ack back one cycle later", 32'(ack), 1);

    // R2 R5 DM block
    do_latch(16'h000A);
    do_write(16'h1111); do_write(16'h2222); do_write(16'h3333);
    do_latch(16'h000A);
    do_read(r); check(r == 16'h1111, "R5 DM word 0", 32'(r), 32'h1111);
    do_read(r); check(r == 16'h2222, "R5 DM word 1", 32'(r), 32'h2222);
    do_read(r); check(r == 16'h3333, "R2 DM word 2", 32'(r), 32'h3333);

    // R6 PM two halves, upper byte of low half ignored on write
    do_latch(16'h4005);
    do_write(16'hA1B2); do_write(16'hFFC3);
    do_write(16'h0D0E); do_write(16'h770F);
    do_latch(16'h4005);
    do_read(r); check(r == 16'hA1B2, "R6 PM hi half", 32'(r), 32'hA1B2);
    do_read(r); check(r == 16'h00C3, "R6 PM lo half", 32'(r), 32'h00C3);
    do_read(r); check(r == 16'h0D0E, "R6 PM next word hi", 32'(r), 32'h0D0E);
    do_read(r); check(r == 16'h000F, "R6 PM next word lo", 32'(r), 32'h000F);

    // R3 overlay select keeps address
    do_latch(16'h4005);
    do_latch(16'h803C);
    check(ovl == 8'h3C, "R3 overlay loaded", 32'(ovl), 32'h3C);
    do_read(r); check(r == 16'hA1B2, "R3 address kept by overlay latch", 32'(r), 32'hA1B2);
    do_latch(16'h8155);
    check(ovl == 8'h3C, "R3 malformed overlay ignored", 32'(ovl), 32'h3C);

    // R4 strobes ignored without select
    @(negedge clk); sel = 1'b0; ad_in = 16'h0020; latch = 1'b1;
    repeat (4) @(negedge clk); latch = 1'b0;
    repeat (4) @(negedge clk); wr = 1'b1;
    repeat (4) @(negedge clk); wr = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!ack) check(1'b0, "R4 ack stays high without select", 32'(ack), 1);
    end
    check(ack == 1'b1, "R4 no phase without select", 32'(ack), 1);
    sel = 1'b1;
    repeat (4) @(negedge clk);
    do_read(r); check(r == 16'h00C3, "R4 address untouched", 32'(r), 32'h00C3);

    // R8 control block write-protected
    do_latch(16'd230);
    do_read(v);
    do_latch(16'd230);
    do_write(~v);
    do_latch(16'd230);
    do_read(r); check(r == v, "R8 control block unchanged", 32'(r), 32'(v));
    do_latch(16'd223);
    do_write(16'h5A5A);
    do_write(16'h1234);
    do_latch(16'd223);
    do_read(r); check(r == 16'h5A5A, "R8 last open word writable", 32'(r), 32'h5A5A);

    // R9 out of range, address wraps to 0
    do_latch(16'h3FFF);
    do_read(r); check(r == 16'h0000, "R9 DM out of range reads zero", 32'(r), 0);
    do_latch(16'h3FFF);
    do_write(16'h1234); do_write(16'hABCD);
    do_latch(16'h0000);
    do_read(r); check(r == 16'hABCD, "R5 wrap to word 0", 32'(r), 32'hABCD);
    do_latch(16'h412C);
    do_write(16'h7777); do_write(16'h0088);
    do_latch(16'h412C);
    do_read(r); check(r == 16'h0000, "R9 PM out of range hi", 32'(r), 0);
    do_read(r); check(r == 16'h0000, "R9 PM out of range lo", 32'(r), 0);

    // R7 grant holds the access
    do_latch(16'h0030);
    @(negedge clk); grant = 1'b0; ad_in = 16'h4242; wr = 1'b1;
    repeat (4) @(negedge clk); wr = 1'b0;
    repeat (8) @(negedge clk);
    check(ack == 1'b0, "R7 waits for grant", 32'(ack), 0);
    grant = 1'b1;
    @(negedge clk);
    check(ack == 1'b1, "R7 completes after grant", 32'(ack), 1);
    do_latch(16'h0030);
    do_read(r); check(r == 16'h4242, "R7 granted write stored", 32'(r), 32'h4242);
    check(oe == 1'b0, "R11 oe drops after read", 32'(oe), 0);

    // random blocks
    for (int it = 0; it < 16; it++) begin
      int n, a;
      bit pm;
      n  = $urandom_range(1, 6);
      pm = 1'($urandom_range(0, 1));
      if (pm) begin
        a = $urandom_range(0, 240);
        do_latch(16'h4000 | 16'(a));
        for (int k = 0; k < n; k++) begin
          pw[k] = 24'($urandom);
          do_write(pw[k][23:8]);
          do_write({8'($urandom), pw[k][7:0]});
        end
        do_latch(16'h4000 | 16'(a));
        for (int k = 0; k < n; k++) begin
          do_read(r); check(r == pw[k][23:8], "R6 random PM hi", 32'(r), 32'(pw[k][23:8]));
          do_read(r); check(r == {8'h00, pw[k][7:0]}, "R6 random PM lo", 32'(r), 32'(pw[k][7:0]));
        end
      end else begin
        a = $urandom_range(0, 200);
        do_latch(16'(a));
        for (int k = 0; k < n; k++) begin
          dw[k] = 16'($urandom);
          do_write(dw[k]);
        end
        do_latch(16'(a));
        for (int k = 0; k < n; k++) begin
          do_read(r); check(r == dw[k], "R5 random DM", 32'(r), 32'(dw[k]));
        end
      end
    end

    summary();
  end
endmodule